// File: doc/BRIEF.md
# Test Access Port with Instruction Decode and Bypass

This block is the test access port of a chip: a 16-state controller stepped by the test clock and the mode-select input. Behind the controller sit a 4-bit instruction register, a 1-bit bypass register and the serial output stage. The current instruction is decoded into two groups of controls. The first group chooses which data register sits between the serial input and output: either the bypass bit, or the external boundary-scan chain, which reaches this block only through a select line, three state strobes and a serial return input. The second group drives the chip's output pads: one global driver enable, and one select that feeds the drivers from the boundary-scan cells instead of from the core.

Two instructions float every output driver and put the bypass bit in the scan path. With the high-impedance instruction the drivers simply go quiet. With the clamp-to-float instruction the disabled drivers still take their data from the boundary-scan cells, so production test can confirm that each driver switches off whatever value it is given. The instructions that use the boundary-scan chain are external test, sample/preload and internal test. Internal test also steers the core's inputs from the boundary-scan cells.

Top module: `jtag_tap_decode`

## Requirements
- R1: While trstN is low, the controller is in Test-Logic-Reset, the current instruction is BYPASS (1111), tdoOe is 0, outEnable is 1, and padFromBsr, coreFromBsr and bsrSelect are 0.
- R2: The controller follows the standard 16-state transition graph on tms, sampled at the rising edge of tck. Five consecutive rising edges with tms high reach Test-Logic-Reset from any state, and that state restores BYPASS as the current instruction.
- R3: In CAPTURE-IR the instruction shift register loads 0001. In SHIFT-IR it shifts toward bit 0, and bit 0 goes out first, so the first four bits on tdo are 1, 0, 0, 0.
- R4: A shifted instruction becomes current only on the rising edge of tck taken in UPDATE-IR. outEnable, padFromBsr, coreFromBsr and bsrSelect change only then, or on a return to Test-Logic-Reset.
- R5: When the bypass bit is the data register, CAPTURE-DR loads 0 into it. In SHIFT-DR each tdi bit comes out on tdo one tck cycle later, so the first bit out is 0.
- R6: The bypass bit keeps its value through EXIT1-DR, PAUSE-DR and EXIT2-DR. On re-entry to SHIFT-DR without a capture, the first bit out is the last bit shifted in.
- R7: EXTEST (0000), SAMPLE/PRELOAD (0011) and INTEST (1100) set bsrSelect to 1. During SHIFT-DR, tdo then carries bsrTdo.
- R8: HIGHZ (0111) sets outEnable to 0 and padFromBsr to 0, and selects the bypass bit.
- R9: CLAMPZ (1001) sets outEnable to 0 and padFromBsr to 1, and selects the bypass bit.
- R10: EXTEST gives outEnable 1, padFromBsr 1, coreFromBsr 0. SAMPLE/PRELOAD gives 1, 0, 0. INTEST gives 1, 1, 1.
- R11: BYPASS (1111) and every code not listed above select the bypass bit, with outEnable 1, padFromBsr 0 and coreFromBsr 0.
- R12: tdo and tdoOe change only on the falling edge of tck. tdoOe is 1 exactly in the low phases that follow a rising edge into SHIFT-IR or SHIFT-DR.
- R13: drCapture, drShift and drUpdate are 1 while the controller is in CAPTURE-DR, SHIFT-DR and UPDATE-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bsrTdo | input | 1 | Serial return from the external boundary-scan chain |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdoOe | output | 1 | Drive enable for the tdo pad; pad floats when 0 |
| bsrSelect | output | 1 | Boundary-scan chain is the selected data register |
| drCapture | output | 1 | Controller is in CAPTURE-DR |
| drShift | output | 1 | Controller is in SHIFT-DR |
| drUpdate | output | 1 | Controller is in UPDATE-DR |
| outEnable | output | 1 | Global enable for the chip's output drivers |
| padFromBsr | output | 1 | Output drivers take data from boundary-scan cells |
| coreFromBsr | output | 1 | Core inputs take data from boundary-scan cells |

## Verification
The properties assume that tms, tdi and bsrTdo change only while tck is low, and that trstN is released while tck is low. The sampled values at each rising edge are then the ones the controller acts on. The bench drives every input one time unit after a falling edge and samples outputs shortly after that falling edge, well clear of the next rising edge. bsrTdo is held at a constant 1 so that a boundary-scan path can be told apart from the bypass bit. Reset is asserted asynchronously only during a low phase of tck.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IrLen = 4;
  typedef logic [IrLen-1:0] irCode_t;

  localparam irCode_t OpExtest  = 4'b0000;
  localparam irCode_t OpSample  = 4'b0011;
  localparam irCode_t OpHighz   = 4'b0111;
  localparam irCode_t OpClampz  = 4'b1001;
  localparam irCode_t OpIntest  = 4'b1100;
  localparam irCode_t OpBypass  = 4'b1111;
  localparam irCode_t IrCaptVal = 4'b0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic tlr;
    logic capIr;
    logic shiftIr;
    logic updIr;
    logic capDr;
    logic shiftDr;
    logic updDr;
  } tapStrobe_t;

  // decoded instruction controls
  typedef struct packed {
    logic bsrSel;
    logic drvEn;
    logic drvFromBsr;
    logic coreFromBsr;
  } drvCtl_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  curState,
  output tapStrobe_t strb
);

  tapState_e nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_TLR:      nextState = tms ? ST_TLR      : ST_RTI;
      ST_RTI:      nextState = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nextState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   nextState = tms ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nextState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_RTI;
      default:     nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) curState <= ST_TLR;
    else        curState <= nextState;
  end

  always_comb begin
    strb.tlr     = (curState == ST_TLR);
    strb.capIr   = (curState == ST_CAP_IR);
    strb.shiftIr = (curState == ST_SHIFT_IR);
    strb.updIr   = (curState == ST_UPD_IR);
    strb.capDr   = (curState == ST_CAP_DR);
    strb.shiftDr = (curState == ST_SHIFT_DR);
    strb.updDr   = (curState == ST_UPD_DR);
  end

endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import jtag_tap_pkg::*;
(
  input  irCode_t instr,
  output drvCtl_t ctl
);

  always_comb begin
    // bypass with normal drivers unless a listed code says otherwise
    ctl = '{bsrSel: 1'b0, drvEn: 1'b1, drvFromBsr: 1'b0, coreFromBsr: 1'b0};
    unique case (instr)
      OpExtest: ctl = '{bsrSel: 1'b1, drvEn: 1'b1, drvFromBsr: 1'b1, coreFromBsr: 1'b0};
      OpSample: ctl = '{bsrSel: 1'b1, drvEn: 1'b1, drvFromBsr: 1'b0, coreFromBsr: 1'b0};
      OpIntest: ctl = '{bsrSel: 1'b1, drvEn: 1'b1, drvFromBsr: 1'b1, coreFromBsr: 1'b1};
      OpHighz:  ctl = '{bsrSel: 1'b0, drvEn: 1'b0, drvFromBsr: 1'b0, coreFromBsr: 1'b0};
      OpClampz: ctl = '{bsrSel: 1'b0, drvEn: 1'b0, drvFromBsr: 1'b1, coreFromBsr: 1'b0};
      default:  ;
    endcase
  end

endmodule

// File: rtl/tap_dp.sv
module tap_dp
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  logic       bsrTdo,
  input  tapStrobe_t strb,
  output irCode_t    curInstr,
  output drvCtl_t    ctl,
  output logic       tdo,
  output logic       tdoOe
);

  irCode_t irShift;
  logic    bypassBit;
  logic    tdoNext;

  // instruction shift stage: capture fixed pattern, shift toward bit 0
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irShift <= IrCaptVal;
    else if (strb.capIr)   irShift <= IrCaptVal;
    else if (strb.shiftIr) irShift <= {tdi, irShift[IrLen-1:1]};
  end

  // current instruction: changes only in update or logic reset
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          curInstr <= OpBypass;
    else if (strb.tlr)   curInstr <= OpBypass;
    else if (strb.updIr) curInstr <= irShift;
  end

  tap_ir_decode u_dec (
    .instr (curInstr),
    .ctl   (ctl)
  );

  // single bypass bit, only touched while it is the selected register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                          bypassBit <= 1'b0;
    else if (strb.capDr && !ctl.bsrSel)   bypassBit <= 1'b0;
    else if (strb.shiftDr && !ctl.bsrSel) bypassBit <= tdi;
  end

  always_comb begin
    if (strb.shiftIr)     tdoNext = irShift[0];
    else if (ctl.bsrSel)  tdoNext = bsrTdo;
    else                  tdoNext = bypassBit;
  end

  // output stage retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= tdoNext;
      tdoOe <= strb.shiftIr | strb.shiftDr;
    end
  end

endmodule

// File: rtl/jtag_tap_decode.sv
module jtag_tap_decode
  import jtag_tap_pkg::*;
(
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic bsrTdo,
  output logic tdo,
  output logic tdoOe,
  output logic bsrSelect,
  output logic drCapture,
  output logic drShift,
  output logic drUpdate,
  output logic outEnable,
  output logic padFromBsr,
  output logic coreFromBsr
);

  tapState_e  curState;
  tapStrobe_t strb;
  irCode_t    curInstr;
  drvCtl_t    ctl;

  tap_ctrl u_ctrl (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .curState (curState),
    .strb     (strb)
  );

  tap_dp u_dp (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .bsrTdo   (bsrTdo),
    .strb     (strb),
    .curInstr (curInstr),
    .ctl      (ctl),
    .tdo      (tdo),
    .tdoOe    (tdoOe)
  );

  assign bsrSelect   = ctl.bsrSel;
  assign outEnable   = ctl.drvEn;
  assign padFromBsr  = ctl.drvFromBsr;
  assign coreFromBsr = ctl.coreFromBsr;
  assign drCapture   = strb.capDr;
  assign drShift     = strb.shiftDr;
  assign drUpdate    = strb.updDr;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
  import jtag_tap_pkg::*;
(
  input logic      tck,
  input logic      trstN,
  input logic      tms,
  input logic      tdi,
  input logic      tdo,
  input logic      tdoOe,
  input tapState_e curState,
  input irCode_t   curInstr,
  input logic      bsrSelect,
  input logic      outEnable,
  input logic      padFromBsr,
  input logic      coreFromBsr
);

  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)         tmsRun <= 3'd0;
    else if (!tms)      tmsRun <= 3'd0;
    else if (tmsRun < 3'd5) tmsRun <= tmsRun + 3'd1;
  end

  // R1: leaving logic reset yields bypass and normal drivers
  a_r1_reset_bypass: assert property (@(posedge tck) disable iff (!trstN)
    curState == ST_TLR |=> (outEnable && !padFromBsr && !coreFromBsr && !bsrSelect));

  // R2: five high tms edges always land in logic reset
  a_r2_tms_reset: assert property (@(posedge tck) disable iff (!trstN)
    tmsRun == 3'd5 |-> curState == ST_TLR);

  // R3: first IR bit out after capture is 1
  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!trstN)
    (curState == ST_SHIFT_IR && $past(curState) == ST_CAP_IR) |-> tdo);

  // R4: controls move only after update-IR or logic reset
  a_r4_ctl_on_update: assert property (@(posedge tck) disable iff (!trstN)
    !$stable({outEnable, padFromBsr, coreFromBsr, bsrSelect}) |->
      ($past(curState) == ST_UPD_IR || $past(curState) == ST_TLR));

  // R5: bypass captures 0 and delays by one cycle
  a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    (curState == ST_SHIFT_DR && $past(curState) == ST_CAP_DR && !bsrSelect) |-> !tdo);

  a_r5_bypass_delay: assert property (@(posedge tck) disable iff (!trstN)
    (curState == ST_SHIFT_DR && $past(curState) == ST_SHIFT_DR && !bsrSelect) |-> tdo == $past(tdi));

  // R7: boundary path only for the three scan instructions
  a_r7_bsr_codes: assert property (@(posedge tck) disable iff (!trstN)
    bsrSelect |-> (curInstr == OpExtest || curInstr == OpSample || curInstr == OpIntest));

  // R8: high-impedance instruction
  a_r8_highz: assert property (@(posedge tck) disable iff (!trstN)
    curInstr == OpHighz |-> (!outEnable && !padFromBsr && !bsrSelect));

  // R9: clamp-to-float instruction
  a_r9_clampz: assert property (@(posedge tck) disable iff (!trstN)
    curInstr == OpClampz |-> (!outEnable && padFromBsr && !bsrSelect));

  // R12: tdo driven exactly in the shift states
  a_r12_oe_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe == (curState == ST_SHIFT_IR || curState == ST_SHIFT_DR));

endmodule

bind jtag_tap_decode tap_chk u_chk (
  .tck         (tck),
  .trstN       (trstN),
  .tms         (tms),
  .tdi         (tdi),
  .tdo         (tdo),
  .tdoOe       (tdoOe),
  .curState    (curState),
  .curInstr    (curInstr),
  .bsrSelect   (bsrSelect),
  .outEnable   (outEnable),
  .padFromBsr  (padFromBsr),
  .coreFromBsr (coreFromBsr)
);

// File: tb/jtag_tap_decode_bench.sv
module jtag_tap_decode_bench;

  logic tck = 1'b0;
  logic trstN, tms, tdi, bsrTdo;
  logic tdo, tdoOe, bsrSelect, drCapture, drShift, drUpdate;
  logic outEnable, padFromBsr, coreFromBsr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic  expQ[$];
  string tagQ[$];

  always #4 tck = ~tck;

  jtag_tap_decode u_jtag_tap_decode (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrTdo(bsrTdo),
    .tdo(tdo), .tdoOe(tdoOe), .bsrSelect(bsrSelect),
    .drCapture(drCapture), .drShift(drShift), .drUpdate(drUpdate),
    .outEnable(outEnable), .padFromBsr(padFromBsr), .coreFromBsr(coreFromBsr)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // {outEnable, padFromBsr, coreFromBsr, bsrSelect}
  function automatic logic [3:0] ctlVec();
    return {outEnable, padFromBsr, coreFromBsr, bsrSelect};
  endfunction

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic push(input logic b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  // scoreboard monitor: every driven tdo bit must match the next expected one
  always @(negedge tck) begin
    #2;
    if (trstN === 1'b1 && tdoOe === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected tdo drive actual %b expected none", tdo);
      end else begin
        automatic logic  e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (tdo !== e) begin
          errors++;
          $display("FAIL %s tdo actual %b expected %b", t, tdo, e);
        end
      end
    end
  end

  // from RTI up to the UPDATE-IR state; caller takes the final step
  task automatic irToUpdate(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0);
    push(1'b1, "R3"); push(1'b0, "R3"); push(1'b0, "R3"); push(1'b0, "R3");
    step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, code[i]);
    step(1, 0);
  endtask

  task automatic loadIr(input logic [3:0] code);
    irToUpdate(code);
    step(0, 0);
  endtask

  // DR scan from RTI back to RTI; bsrPath picks the expected source
  task automatic scanDr(input logic [15:0] inBits, input int n, input bit bsrPath, input string t);
    step(1, 0);
    step(0, 0);
    chk("R13 drCapture", {3'b0, drCapture}, 4'b0001);
    for (int i = 0; i < n; i++) begin
      if (bsrPath)     push(1'b1, t);
      else if (i == 0) push(1'b0, t);
      else             push(inBits[i-1], t);
    end
    step(0, 0);
    chk("R13 drShift", {3'b0, drShift}, 4'b0001);
    for (int i = 0; i < n; i++) step(i == n - 1, inBits[i]);
    step(1, 0);
    chk("R13 drUpdate", {3'b0, drUpdate}, 4'b0001);
    step(0, 0);
  endtask

  initial begin
    trstN = 1'b0; tms = 1'b1; tdi = 1'b0; bsrTdo = 1'b1;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset controls", ctlVec(), 4'b1000);
    chk("R1 reset tdoOe", {3'b0, tdoOe}, 4'b0000);
    trstN = 1'b1;
    step(0, 0);
    chk("R12 tdoOe idle", {3'b0, tdoOe}, 4'b0000);

    // R3 capture pattern + R11 explicit bypass code
    loadIr(4'b1111);
    chk("R11 bypass code", ctlVec(), 4'b1000);
    scanDr(16'b0000_0000_0100_1101, 8, 1'b0, "R5 bypass");
    scanDr(16'b0000_0000_1011_0010, 8, 1'b0, "R5 bypass b");

    // R6 hold through pause
    step(1, 0); step(0, 0);
    push(1'b0, "R6 capture");
    step(0, 0);
    step(1, 1);
    step(0, 0);
    step(1, 0);
    push(1'b1, "R6 held bit");
    step(0, 0);
    step(1, 0); step(1, 0); step(0, 0);

    // R4 + R8 high impedance
    irToUpdate(4'b0111);
    chk("R4 unchanged in update", ctlVec(), 4'b1000);
    step(0, 0);
    chk("R8 highz controls", ctlVec(), 4'b0000);
    scanDr(16'b0000_0000_0000_0111, 4, 1'b0, "R8 bypass path");

    // R9 clamp
    loadIr(4'b1001);
    chk("R9 clampz controls", ctlVec(), 4'b0100);
    scanDr(16'b0000_0000_0000_1010, 5, 1'b0, "R9 bypass path");

    // R7 + R10 boundary-scan instructions
    loadIr(4'b0000);
    chk("R10 extest controls", ctlVec(), 4'b1101);
    scanDr(16'h0000, 6, 1'b1, "R7 extest path");
    loadIr(4'b0011);
    chk("R10 sample controls", ctlVec(), 4'b1001);
    scanDr(16'h0000, 5, 1'b1, "R7 sample path");
    irToUpdate(4'b1100);
    chk("R4 unchanged before update", ctlVec(), 4'b1001);
    step(0, 0);
    chk("R10 intest controls", ctlVec(), 4'b1111);
    scanDr(16'h0000, 4, 1'b1, "R7 intest path");

    // R11 undefined code
    loadIr(4'b0101);
    chk("R11 undefined code", ctlVec(), 4'b1000);
    scanDr(16'b0000_0000_0001_1001, 6, 1'b0, "R11 bypass path");

    // R2 tms reset from extest
    loadIr(4'b0000);
    chk("R2 preload extest", ctlVec(), 4'b1101);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 tms reset", ctlVec(), 4'b1000);
    step(0, 0);

    // R1 asynchronous reset mid-operation
    loadIr(4'b1001);
    trstN = 1'b0;
    #2;
    chk("R1 async reset controls", ctlVec(), 4'b1000);
    chk("R1 async reset tdoOe", {3'b0, tdoOe}, 4'b0000);
    @(negedge tck);
    #1;
    trstN = 1'b1;
    step(0, 0);
    scanDr(16'b0000_0000_0000_0110, 4, 1'b0, "R1 bypass after reset");

    repeat (2) step(0, 0);
    chk("R12 queue drained", expQ.size() == 0 ? 4'b0000 : 4'b0001, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule